// File: doc/BRIEF.md
# Microcoded 16-bit Datapath Controller

This block executes one 8-bit microcode byte per clock against a small 16-bit datapath that it owns. That datapath is a sixteen-entry register file, a 32-bit working register B kept as a high and a low 16-bit half, two 32-bit pointers (program counter PC and address pointer A, each a {high, low} pair of 16-bit halves), an instruction register and a 4-bit cycle counter. The upper nibble of the byte selects one of sixteen code groups. In register-transfer groups the lower nibble is the register index. A decoder turns the byte into one decode class, and the core applies that class to its state on the next rising edge.

The decode classes are: IDLE (silent and every unassigned code), SHL1, SHL0, SHR1, SHR0, PC_INC, A_INC, CYC_CLR, IR_LD, BH_LD, BL_LD, R_FROM_BH, R_FROM_BL, AH_LD, AL_LD, PC_LD, MEM_WR, R_FROM_MEM and R_FROM_IMM. There is no stored sequencing state: every cycle is an independent transition from the current datapath state, chosen by the class of the byte present on that edge. Memory is addressed by A at all times. A write lasts exactly as long as its code is presented.

Top module: `mcdp_core`

## Requirements
- R1: A synchronous reset clears every register-file entry, B, PC, A, the instruction register and the cycle counter to zero.
- R2: The 4-bit cycle counter increments by one, wrapping 15 to 0, on every clock whose code is not 8'h07. Silent and unassigned codes also count.
- R3: Code 8'h07 sets the cycle counter to 0 on the next edge.
- R4: Code 8'h00 and every unassigned code (group 0 low nibble 9..F, groups B..F) change no state other than the cycle counter, and hold mem_we low.
- R5: Code 1n loads B high from register n and 2n loads B low from register n. Code 3n writes B high into register n and 4n writes B low into register n.
- R6: In group 7, an odd n loads PC high from register n and an even n loads PC low from register n. The other half is untouched.
- R7: Code 8'h05 adds one to the 32-bit PC and code 8'h06 adds one to the 32-bit A, each with carry from the low half into the high half.
- R8: B is shifted as one 32-bit value {high, low}. Code 01 shifts left with fill 1, 02 shifts left with fill 0, 03 shifts right with fill 1, and 04 shifts right with fill 0.
- R9: Code 8n raises mem_we for the cycle that code is present and drives register n on mem_wdata. mem_addr always equals {A high, A low}. When no write code is present, mem_we and mem_wdata are 0.
- R10: Code 9n writes mem_rdata into register n, code An writes imm into register n, and code 8'h08 loads the instruction register from mem_rdata.
- R11: Code 5n loads A high from register n and code 6n loads A low from register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ucode | input | 8 | Microcode byte for this cycle |
| mem_rdata | input | 16 | Memory read data |
| imm | input | 16 | Immediate value |
| mem_addr | output | 32 | Memory address, {A high, A low} |
| mem_wdata | output | 16 | Write data, register n during code 8n |
| mem_we | output | 1 | Write strobe |
| b_out | output | 32 | B register {high, low} |
| pc_out | output | 32 | Program counter {high, low} |
| ir_out | output | 16 | Instruction register |
| cyc_out | output | 4 | Cycle counter |
| regs_out | output | 256 | Register file, entry k in bits 16k+15..16k |

## Verification
The register file is seeded through the immediate path with distinct values. Every transfer group then runs with both odd and even indices, so a swapped half, a wrong index or an ignored parity bit shows up as a wrong value in a distinct register. All-ones low halves are loaded into PC and A before their increments, which separates a 32-bit carry from a 16-bit wrap. Patterned B values run through all four shifts, which tells fill 1 from fill 0 and shows whether bits cross between the halves. Silent and unassigned codes are mixed into the sequence, long runs wrap the cycle counter, and the clear code is placed mid-stream, so counting on idle cycles, wrapping and clearing are each checked on their own.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
    localparam int NREG = 16;
    localparam int IDXW = 4;

    typedef enum logic [4:0] {
        OP_IDLE, OP_SHL1, OP_SHL0, OP_SHR1, OP_SHR0,
        OP_PC_INC, OP_A_INC, OP_CYC_CLR, OP_IR_LD,
        OP_BH_LD, OP_BL_LD, OP_R_FROM_BH, OP_R_FROM_BL,
        OP_AH_LD, OP_AL_LD, OP_PC_LD,
        OP_MEM_WR, OP_R_FROM_MEM, OP_R_FROM_IMM
    } op_kind_t;

    typedef struct packed {
        op_kind_t         kind;
        logic [IDXW-1:0]  idx;
    } uop_t;
endpackage

// File: rtl/mcdp_decode.sv
module mcdp_decode
    import mcdp_pkg::*;
(
    input  logic [7:0] code,
    output uop_t       uop
);
    always_comb begin
        uop.idx  = code[3:0];
        uop.kind = OP_IDLE;
        unique case (code[7:4])
            4'h0: begin
                unique case (code[3:0])
                    4'h1:    uop.kind = OP_SHL1;
                    4'h2:    uop.kind = OP_SHL0;
                    4'h3:    uop.kind = OP_SHR1;
                    4'h4:    uop.kind = OP_SHR0;
                    4'h5:    uop.kind = OP_PC_INC;
                    4'h6:    uop.kind = OP_A_INC;
                    4'h7:    uop.kind = OP_CYC_CLR;
                    4'h8:    uop.kind = OP_IR_LD;
                    default: uop.kind = OP_IDLE;
                endcase
            end
            4'h1:    uop.kind = OP_BH_LD;
            4'h2:    uop.kind = OP_BL_LD;
            4'h3:    uop.kind = OP_R_FROM_BH;
            4'h4:    uop.kind = OP_R_FROM_BL;
            4'h5:    uop.kind = OP_AH_LD;
            4'h6:    uop.kind = OP_AL_LD;
            4'h7:    uop.kind = OP_PC_LD;
            4'h8:    uop.kind = OP_MEM_WR;
            4'h9:    uop.kind = OP_R_FROM_MEM;
            4'hA:    uop.kind = OP_R_FROM_IMM;
            default: uop.kind = OP_IDLE;
        endcase
    end
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
    import mcdp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDXW-1:0]      sel,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [NREG*DW-1:0]   flat
);
    logic [DW-1:0] cells [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[k] <= '0;
            else if (we && sel == IDXW'(k))
                cells[k] <= wdata;
        end
        assign flat[k*DW +: DW] = cells[k];
    end

    assign rdata = cells[sel];
endmodule

// File: rtl/mcdp_ptr.sv
module mcdp_ptr #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_hi,
    input  logic            ld_lo,
    input  logic            inc,
    input  logic [HW-1:0]   din,
    output logic [2*HW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (inc)   q <= q + 1'b1;
        else if (ld_hi) q[2*HW-1:HW] <= din;
        else if (ld_lo) q[HW-1:0] <= din;
    end
endmodule

// File: rtl/mcdp_core.sv
module mcdp_core
    import mcdp_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           ucode,
    input  logic [DW-1:0]        mem_rdata,
    input  logic [DW-1:0]        imm,
    output logic [2*DW-1:0]      mem_addr,
    output logic [DW-1:0]        mem_wdata,
    output logic                 mem_we,
    output logic [2*DW-1:0]      b_out,
    output logic [2*DW-1:0]      pc_out,
    output logic [DW-1:0]        ir_out,
    output logic [CW-1:0]        cyc_out,
    output logic [NREG*DW-1:0]   regs_out
);
    localparam int PW = 2 * DW;

    uop_t          uop;
    logic [DW-1:0] rd_val;
    logic          rf_we;
    logic [DW-1:0] rf_wdata;
    logic [PW-1:0] b_q;
    logic [DW-1:0] ir_q;
    logic [CW-1:0] cyc_q;

    mcdp_decode u_dec (.code(ucode), .uop(uop));

    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = '0;
        unique case (uop.kind)
            OP_R_FROM_BH:  begin rf_we = 1'b1; rf_wdata = b_q[PW-1:DW]; end
            OP_R_FROM_BL:  begin rf_we = 1'b1; rf_wdata = b_q[DW-1:0];  end
            OP_R_FROM_MEM: begin rf_we = 1'b1; rf_wdata = mem_rdata;    end
            OP_R_FROM_IMM: begin rf_we = 1'b1; rf_wdata = imm;          end
            default:       begin rf_we = 1'b0; rf_wdata = '0;           end
        endcase
    end

    mcdp_regfile #(.DW(DW)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .sel(uop.idx),
        .wdata(rf_wdata), .rdata(rd_val), .flat(regs_out)
    );

    mcdp_ptr #(.HW(DW)) u_pc (
        .clk(clk), .rst(rst),
        .ld_hi(uop.kind == OP_PC_LD && uop.idx[0]),
        .ld_lo(uop.kind == OP_PC_LD && !uop.idx[0]),
        .inc(uop.kind == OP_PC_INC),
        .din(rd_val), .q(pc_out)
    );

    mcdp_ptr #(.HW(DW)) u_ap (
        .clk(clk), .rst(rst),
        .ld_hi(uop.kind == OP_AH_LD),
        .ld_lo(uop.kind == OP_AL_LD),
        .inc(uop.kind == OP_A_INC),
        .din(rd_val), .q(mem_addr)
    );

    // B working register: loads and one-bit shifts with chosen fill
    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else begin
            unique case (uop.kind)
                OP_SHL1:  b_q <= {b_q[PW-2:0], 1'b1};
                OP_SHL0:  b_q <= {b_q[PW-2:0], 1'b0};
                OP_SHR1:  b_q <= {1'b1, b_q[PW-1:1]};
                OP_SHR0:  b_q <= {1'b0, b_q[PW-1:1]};
                OP_BH_LD: b_q[PW-1:DW] <= rd_val;
                OP_BL_LD: b_q[DW-1:0]  <= rd_val;
                default:  b_q <= b_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    ir_q <= '0;
        else if (uop.kind == OP_IR_LD) ir_q <= mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                         cyc_q <= '0;
        else if (uop.kind == OP_CYC_CLR) cyc_q <= '0;
        else                             cyc_q <= cyc_q + 1'b1;
    end

    assign mem_we    = (uop.kind == OP_MEM_WR);
    assign mem_wdata = mem_we ? rd_val : '0;
    assign b_out     = b_q;
    assign ir_out    = ir_q;
    assign cyc_out   = cyc_q;

    a_r2_cyc_step: assert property (@(posedge clk) disable iff (rst)
        (ucode != 8'h07) |=> (cyc_out == $past(cyc_out) + 1'b1));

    a_r3_cyc_clear: assert property (@(posedge clk) disable iff (rst)
        (ucode == 8'h07) |=> (cyc_out == '0));

    a_r4_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (ucode == 8'h00) |=> ($stable(pc_out) && $stable(mem_addr)
                              && $stable(b_out) && $stable(regs_out)));

    a_r4_quiet_nowrite: assert property (@(posedge clk) disable iff (rst)
        (ucode == 8'h00) |-> !mem_we);

    a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
        (ucode == 8'h05) |=> (pc_out == $past(pc_out) + 1'b1));

    a_r9_we_group: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (ucode[7:4] == 4'h8));
endmodule

// File: tb/mcdp_core_test.sv
module mcdp_core_test;
    typedef struct {
        logic [255:0] regs;
        logic [31:0]  b;
        logic [31:0]  pc;
        logic [31:0]  a;
        logic [15:0]  ir;
        logic [3:0]   cyc;
        string        tag;
    } snap_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   ucode = 8'h00;
    logic [15:0]  mem_rdata = '0;
    logic [15:0]  imm = '0;
    logic [31:0]  mem_addr;
    logic [15:0]  mem_wdata;
    logic         mem_we;
    logic [31:0]  b_out, pc_out;
    logic [15:0]  ir_out;
    logic [3:0]   cyc_out;
    logic [255:0] regs_out;

    int checks = 0;
    int fails  = 0;
    snap_t sb[$];

    logic [15:0] m_r [16];
    logic [31:0] m_b, m_pc, m_a;
    logic [15:0] m_ir;
    logic [3:0]  m_cyc;

    mcdp_core uut (
        .clk(clk), .rst(rst), .ucode(ucode), .mem_rdata(mem_rdata), .imm(imm),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .b_out(b_out), .pc_out(pc_out), .ir_out(ir_out), .cyc_out(cyc_out),
        .regs_out(regs_out)
    );

    always #10 clk = ~clk;

    function automatic logic [255:0] flat_model();
        logic [255:0] f;
        for (int k = 0; k < 16; k++) f[k*16 +: 16] = m_r[k];
        return f;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: present a code, check the write port, predict, push expected
    task automatic op(input logic [7:0] c, input logic [15:0] im,
                      input logic [15:0] rd, input string tag);
        int n;
        snap_t s;
        n = int'(c[3:0]);
        ucode = c; imm = im; mem_rdata = rd;
        #1;
        if (c[7:4] == 4'h8) begin
            check(mem_we === 1'b1, "R9", "we", 256'(mem_we), 256'd1);
            check(mem_wdata === m_r[n], "R9", "wdata", 256'(mem_wdata), 256'(m_r[n]));
            check(mem_addr === m_a, "R9", "addr", 256'(mem_addr), 256'(m_a));
        end else begin
            check(mem_we === 1'b0 && mem_wdata === 16'h0, tag, "no write",
                  256'({mem_we, mem_wdata}), 256'd0);
        end
        unique case (c[7:4])
            4'h0: begin
                case (c[3:0])
                    4'h1: m_b = {m_b[30:0], 1'b1};
                    4'h2: m_b = {m_b[30:0], 1'b0};
                    4'h3: m_b = {1'b1, m_b[31:1]};
                    4'h4: m_b = {1'b0, m_b[31:1]};
                    4'h5: m_pc = m_pc + 32'd1;
                    4'h6: m_a = m_a + 32'd1;
                    4'h8: m_ir = rd;
                    default: ;
                endcase
            end
            4'h1: m_b[31:16] = m_r[n];
            4'h2: m_b[15:0] = m_r[n];
            4'h3: m_r[n] = m_b[31:16];
            4'h4: m_r[n] = m_b[15:0];
            4'h5: m_a[31:16] = m_r[n];
            4'h6: m_a[15:0] = m_r[n];
            4'h7: if (n % 2 == 1) m_pc[31:16] = m_r[n]; else m_pc[15:0] = m_r[n];
            4'h9: m_r[n] = rd;
            4'hA: m_r[n] = im;
            default: ;
        endcase
        m_cyc = (c == 8'h07) ? 4'd0 : m_cyc + 4'd1;
        s.regs = flat_model(); s.b = m_b; s.pc = m_pc; s.a = m_a;
        s.ir = m_ir; s.cyc = m_cyc; s.tag = tag;
        sb.push_back(s);
        @(negedge clk);
    endtask

    // monitor: compare the state after each edge with the oldest prediction
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            snap_t e;
            e = sb.pop_front();
            check(regs_out === e.regs, e.tag, "regs", regs_out, e.regs);
            check(b_out === e.b, e.tag, "b", 256'(b_out), 256'(e.b));
            check(pc_out === e.pc, e.tag, "pc", 256'(pc_out), 256'(e.pc));
            check(mem_addr === e.a, e.tag, "a", 256'(mem_addr), 256'(e.a));
            check(ir_out === e.ir, e.tag, "ir", 256'(ir_out), 256'(e.ir));
            check(cyc_out === e.cyc, e.tag, "cyc", 256'(cyc_out), 256'(e.cyc));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) m_r[k] = '0;
        m_b = '0; m_pc = '0; m_a = '0; m_ir = '0; m_cyc = '0;
        repeat (3) @(negedge clk);
        // R1: state after reset
        check(regs_out === '0 && b_out === '0 && pc_out === '0 && mem_addr === '0
              && ir_out === '0 && cyc_out === '0, "R1", "reset",
              {regs_out[127:0], b_out, pc_out, mem_addr, ir_out, cyc_out, 12'h0}, 256'd0);
        rst = 1'b0;
        op(8'h00, 16'h0, 16'h0, "R4");
        // R10: seed all registers through the immediate path
        for (int k = 0; k < 16; k++)
            op(8'hA0 | 8'(k), 16'h1000 + 16'(k) * 16'h0111, 16'h0, "R10");
        op(8'hA0, 16'hFFFF, 16'h0, "R10");
        op(8'hA1, 16'hFFFF, 16'h0, "R10");
        op(8'hA2, 16'h0000, 16'h0, "R10");
        // R6: parity-steered program counter loads, then R7 carry
        op(8'h71, 16'h0, 16'h0, "R6");
        op(8'h70, 16'h0, 16'h0, "R6");
        op(8'h05, 16'h0, 16'h0, "R7");
        op(8'h73, 16'h0, 16'h0, "R6");
        op(8'h74, 16'h0, 16'h0, "R6");
        op(8'h05, 16'h0, 16'h0, "R7");
        // R11 then R7 on the address pointer
        op(8'h52, 16'h0, 16'h0, "R11");
        op(8'h61, 16'h0, 16'h0, "R11");
        op(8'h06, 16'h0, 16'h0, "R7");
        op(8'h5B, 16'h0, 16'h0, "R11");
        op(8'h6C, 16'h0, 16'h0, "R11");
        // R5: B loads and stores
        op(8'h17, 16'h0, 16'h0, "R5");
        op(8'h28, 16'h0, 16'h0, "R5");
        op(8'h3E, 16'h0, 16'h0, "R5");
        op(8'h4D, 16'h0, 16'h0, "R5");
        // R8: shifts with each fill
        op(8'h01, 16'h0, 16'h0, "R8");
        op(8'h01, 16'h0, 16'h0, "R8");
        op(8'h02, 16'h0, 16'h0, "R8");
        op(8'h03, 16'h0, 16'h0, "R8");
        op(8'h04, 16'h0, 16'h0, "R8");
        op(8'h04, 16'h0, 16'h0, "R8");
        op(8'h10, 16'h0, 16'h0, "R8");
        op(8'h22, 16'h0, 16'h0, "R8");
        op(8'h04, 16'h0, 16'h0, "R8");
        op(8'h01, 16'h0, 16'h0, "R8");
        // R4: silent and unassigned codes
        op(8'h00, 16'h5555, 16'hAAAA, "R4");
        op(8'h0C, 16'h5555, 16'hAAAA, "R4");
        op(8'hB3, 16'h5555, 16'hAAAA, "R4");
        op(8'hF5, 16'h5555, 16'hAAAA, "R4");
        // R9: memory writes; R10: memory reads and IR
        op(8'h85, 16'h0, 16'h0, "R9");
        op(8'h00, 16'h0, 16'h0, "R9");
        op(8'h8E, 16'h0, 16'h0, "R9");
        op(8'h9A, 16'h0, 16'hBEEF, "R10");
        op(8'h08, 16'h0, 16'hC0DE, "R10");
        op(8'h8A, 16'h0, 16'h0, "R9");
        // R3 mid-stream clear, then R2 wrap over a long idle run
        op(8'h07, 16'h0, 16'h0, "R3");
        for (int k = 0; k < 18; k++) op(8'h00, 16'h0, 16'h0, "R2");
        op(8'h07, 16'h0, 16'h0, "R3");
        op(8'h07, 16'h0, 16'h0, "R3");
        op(8'h00, 16'h0, 16'h0, "R2");
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule